// File: doc/BRIEF.md
# Linear-Table IO Address Translator

This block sits between one client master and the memory system and rewrites each device virtual address into a physical address. The mapping lives in memory as a flat array of 32-bit words, one word per 4 KiB page, and each word holds the physical page number for one virtual page. A small register port sets up the translation window: the first virtual page, how many pages follow it, the physical page where the table starts, and the fallback pages that take accesses which miss the window. A four-entry, fully associative cache keeps recently used page numbers, so only the first access to a page costs a table read.

A request is a virtual address plus a read/write flag, presented with a valid/ready handshake. A cache hit, a window miss (fault) or untranslated traffic is accepted at once, and the physical address appears on the registered response one cycle later. A cache miss holds ready low. The block issues exactly one table read, waits for the data, loads the cache, and then accepts the still-pending request. Faults never abort. They are steered to a fallback page with the page offset kept, and they latch a sticky flag.

Top module: `lin_xlat`

## Requirements
- R1: After reset, the control word (index 1) reads 0 and the page range (index 4) reads 0x0000FFFF, which is a 65536-page window. The version word (index 0) carries the variant code in bits 15:8, where 1 means split read/write fallback pages. rsp_valid and fault_flag are low.
- R2: While control bit 0 is clear or control bit 4 is set, the response address equals the request address and no table read is issued.
- R3: On a cache miss inside the window, one table read is issued at table_base_page*4096 + (va_page − first_page)*4. req_ready stays low until that read returns. The response is then (entry[19:0] << 12) | va[11:0].
- R4: A later access to a cached page completes on the first cycle it is presented, with no table read and the same translation.
- R5: A page below the first page, or more than the range above it, is a fault. The response is (fallback_page << 12) | va[11:0] with rsp_fault high and no table read, and fault_flag goes high and stays high until reset.
- R6: A faulting read uses the read fallback page (index 6) and a faulting write uses the write fallback page (index 7).
- R7: A write of any value to the flush word (index 2) invalidates every cache entry, so the next access to each page re-reads the table.
- R8: The cache holds four pages and replaces them in round-robin order. After five distinct pages are filled from empty, the first one is evicted and the others still hit.
- R9: rsp_valid is high exactly in the cycle after each accepted request, and a table read request lasts one cycle.
- R10: Control bits 0, 1 and 4 are writable and read back. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe, data valid next cycle |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | Request is a write |
| req_va | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response valid, one cycle after accept |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Response was redirected by a fault |
| fault_flag | output | 1 | Sticky fault indication |
| tbl_req | output | 1 | Table read request pulse |
| tbl_addr | output | 32 | Byte address of the table word |
| tbl_rvalid | input | 1 | Table read data valid |
| tbl_rdata | input | 32 | Table word |

## Verification
The hardest state to reach from the ports is the cache replacement order. After a flush, the bench fills the cache with exactly five distinct pages, so the round-robin pointer wraps once. It then probes a page that should survive and a page that should be gone, counting table reads on the memory side. A stale hit is just as hard to show directly. The bench therefore edits a table word behind the cache's back and shows that the old translation persists until the flush word is written.

// File: rtl/lin_xlat_pkg.sv
package lin_xlat_pkg;
  // register word indices
  localparam logic [2:0] RIX_VERSION = 3'd0;
  localparam logic [2:0] RIX_CTRL    = 3'd1;
  localparam logic [2:0] RIX_FLUSH   = 3'd2;
  localparam logic [2:0] RIX_FIRST   = 3'd3;
  localparam logic [2:0] RIX_RANGE   = 3'd4;
  localparam logic [2:0] RIX_BASE    = 3'd5;
  localparam logic [2:0] RIX_DFLT_RD = 3'd6;
  localparam logic [2:0] RIX_DFLT_WR = 3'd7;

  // control bit positions
  localparam int CB_EN     = 0;
  localparam int CB_GATE   = 1;
  localparam int CB_BYPASS = 4;
  localparam int VER_LSB   = 8;

  typedef enum logic [0:0] {
    XS_IDLE = 1'b0,
    XS_WAIT = 1'b1
  } xlat_state_e;
endpackage

// File: rtl/lin_xlat_regs.sv
module lin_xlat_regs
  import lin_xlat_pkg::*;
#(
  parameter int VPN_W     = 20,
  parameter int PPN_W     = 20,
  parameter bit SPLIT     = 1'b1,
  parameter int RANGE_RST = 65535
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             xl_en,
  output logic             bypass,
  output logic             flush,
  output logic [VPN_W-1:0] first_vpn,
  output logic [VPN_W-1:0] vpn_range,
  output logic [PPN_W-1:0] tbl_ppn,
  output logic [PPN_W-1:0] dflt_rd,
  output logic [PPN_W-1:0] dflt_wr
);
  localparam logic [31:0] VERSION_WORD = 32'(SPLIT ? 1 : 0) << VER_LSB;

  logic             en_q, gate_q, byp_q;
  logic [VPN_W-1:0] first_q, range_q;
  logic [PPN_W-1:0] base_q, drd_q;
  logic [PPN_W-1:0] dwr_view;
  logic [31:0]      ctrl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      gate_q  <= 1'b0;
      byp_q   <= 1'b0;
      first_q <= '0;
      range_q <= VPN_W'(RANGE_RST);
      base_q  <= '0;
      drd_q   <= '0;
    end else if (we) begin
      case (addr)
        RIX_CTRL: begin
          en_q   <= wdata[CB_EN];
          gate_q <= wdata[CB_GATE];
          byp_q  <= wdata[CB_BYPASS];
        end
        RIX_FIRST:   first_q <= wdata[VPN_W-1:0];
        RIX_RANGE:   range_q <= wdata[VPN_W-1:0];
        RIX_BASE:    base_q  <= wdata[PPN_W-1:0];
        RIX_DFLT_RD: drd_q   <= wdata[PPN_W-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (SPLIT) begin : g_split
      logic [PPN_W-1:0] dwr_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dwr_q <= '0;
        end else if (we && addr == RIX_DFLT_WR) begin
          dwr_q <= wdata[PPN_W-1:0];
        end
      end
      assign dflt_wr  = dwr_q;
      assign dwr_view = dwr_q;
    end else begin : g_shared
      assign dflt_wr  = drd_q;
      assign dwr_view = '0;
    end
  endgenerate

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[CB_EN]     = en_q;
    ctrl_view[CB_GATE]   = gate_q;
    ctrl_view[CB_BYPASS] = byp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      case (addr)
        RIX_VERSION: rdata <= VERSION_WORD;
        RIX_CTRL:    rdata <= ctrl_view;
        RIX_FIRST:   rdata <= 32'(first_q);
        RIX_RANGE:   rdata <= 32'(range_q);
        RIX_BASE:    rdata <= 32'(base_q);
        RIX_DFLT_RD: rdata <= 32'(drd_q);
        RIX_DFLT_WR: rdata <= 32'(dwr_view);
        default:     rdata <= '0;
      endcase
    end
  end

  assign flush     = we && (addr == RIX_FLUSH);
  assign xl_en     = en_q;
  assign bypass    = byp_q;
  assign first_vpn = first_q;
  assign vpn_range = range_q;
  assign tbl_ppn   = base_q;
  assign dflt_rd   = drd_q;

  logic lint_unused;
  assign lint_unused = ^wdata;
endmodule

// File: rtl/lin_xlat_window.sv
module lin_xlat_window #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PG_SHIFT = 12
) (
  input  logic [VA_W-1:0]          va,
  input  logic [VA_W-PG_SHIFT-1:0] first_vpn,
  input  logic [VA_W-PG_SHIFT-1:0] vpn_range,
  input  logic [PA_W-PG_SHIFT-1:0] tbl_ppn,
  output logic                     in_win,
  output logic [PA_W-1:0]          entry_addr
);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int ENT_SHIFT = 2;  // 32-bit entries

  logic [VPN_W-1:0] vpn, delta;
  logic             below, beyond;

  always_comb begin
    vpn        = va[VA_W-1:PG_SHIFT];
    below      = vpn < first_vpn;
    delta      = vpn - first_vpn;
    beyond     = delta > vpn_range;
    in_win     = !below && !beyond;
    entry_addr = {tbl_ppn, {PG_SHIFT{1'b0}}} + (PA_W'(delta) << ENT_SHIFT);
  end
endmodule

// File: rtl/lin_xlat_tlb.sv
module lin_xlat_tlb #(
  parameter int N     = 4,
  parameter int TAG_W = 20,
  parameter int DAT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [DAT_W-1:0] lk_dat,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [DAT_W-1:0] fill_dat
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];
  logic [DAT_W-1:0] dat_q [N];
  logic [IDX_W-1:0] rr_q;

  always_comb begin
    lk_hit = 1'b0;
    lk_dat = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && tag_q[i] == lk_tag) begin
        lk_hit = 1'b1;
        lk_dat = dat_q[i];
      end
    end
  end

  // valid bits and replacement pointer; flush wins over a fill
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (fill) begin
      vld_q[rr_q] <= 1'b1;
      rr_q        <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  // payload storage needs no reset
  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (fill && !flush && rr_q == IDX_W'(g)) begin
          tag_q[g] <= fill_tag;
          dat_q[g] <= fill_dat;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lin_xlat.sv
module lin_xlat
  import lin_xlat_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PG_SHIFT  = 12,
  parameter int TLB_N     = 4,
  parameter bit SPLIT     = 1'b1,
  parameter int RANGE_RST = 65535
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_re,
  input  logic [2:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [VA_W-1:0] req_va,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_pa,
  output logic            rsp_fault,
  output logic            fault_flag,
  output logic            tbl_req,
  output logic [PA_W-1:0] tbl_addr,
  input  logic            tbl_rvalid,
  input  logic [31:0]     tbl_rdata
);
  localparam int VPN_W = VA_W - PG_SHIFT;
  localparam int PPN_W = PA_W - PG_SHIFT;

  logic             xl_en, bypass, flush;
  logic [VPN_W-1:0] first_vpn, vpn_range;
  logic [PPN_W-1:0] tbl_ppn, dflt_rd, dflt_wr;

  lin_xlat_regs #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .SPLIT(SPLIT), .RANGE_RST(RANGE_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .re(cfg_re), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .xl_en(xl_en), .bypass(bypass),
    .flush(flush), .first_vpn(first_vpn), .vpn_range(vpn_range),
    .tbl_ppn(tbl_ppn), .dflt_rd(dflt_rd), .dflt_wr(dflt_wr)
  );

  logic            in_win;
  logic [PA_W-1:0] entry_addr;

  lin_xlat_window #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)
  ) u_win (
    .va(req_va), .first_vpn(first_vpn), .vpn_range(vpn_range),
    .tbl_ppn(tbl_ppn), .in_win(in_win), .entry_addr(entry_addr)
  );

  xlat_state_e      st_q;
  logic [VPN_W-1:0] req_vpn, pend_vpn_q;
  logic             lk_hit, fill;
  logic [PPN_W-1:0] lk_ppn;

  assign req_vpn = req_va[VA_W-1:PG_SHIFT];
  assign fill    = (st_q == XS_WAIT) && tbl_rvalid;

  lin_xlat_tlb #(
    .N(TLB_N), .TAG_W(VPN_W), .DAT_W(PPN_W)
  ) u_tlb (
    .clk(clk), .rst(rst), .flush(flush), .lk_tag(req_vpn),
    .lk_hit(lk_hit), .lk_dat(lk_ppn), .fill(fill),
    .fill_tag(pend_vpn_q), .fill_dat(tbl_rdata[PPN_W-1:0])
  );

  logic            passthru, is_fault, accept, miss;
  logic [PA_W-1:0] next_pa;
  logic [PPN_W-1:0] dflt_sel;

  always_comb begin
    passthru  = !xl_en || bypass;
    is_fault  = !passthru && !in_win;
    req_ready = (st_q == XS_IDLE) && (passthru || !in_win || lk_hit);
    accept    = req_valid && req_ready;
    miss      = req_valid && (st_q == XS_IDLE) && !passthru && in_win && !lk_hit;
    dflt_sel  = req_write ? dflt_wr : dflt_rd;
    if (passthru) begin
      next_pa = PA_W'(req_va);
    end else if (is_fault) begin
      next_pa = {dflt_sel, req_va[PG_SHIFT-1:0]};
    end else begin
      next_pa = {lk_ppn, req_va[PG_SHIFT-1:0]};
    end
  end

  // miss handling: one table read, then refill and retry the lookup
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= XS_IDLE;
      tbl_req    <= 1'b0;
      tbl_addr   <= '0;
      pend_vpn_q <= '0;
    end else begin
      tbl_req <= 1'b0;
      case (st_q)
        XS_IDLE: begin
          if (miss) begin
            st_q       <= XS_WAIT;
            tbl_req    <= 1'b1;
            tbl_addr   <= entry_addr;
            pend_vpn_q <= req_vpn;
          end
        end
        XS_WAIT: begin
          if (tbl_rvalid) begin
            st_q <= XS_IDLE;
          end
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_fault  <= 1'b0;
      fault_flag <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_pa    <= next_pa;
        rsp_fault <= is_fault;
      end
      if (accept && is_fault) begin
        fault_flag <= 1'b1;
      end
    end
  end

  logic lint_unused;
  assign lint_unused = ^tbl_rdata;
endmodule

// File: rtl/lin_xlat_chk.sv
module lin_xlat_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_fault,
  input logic fault_flag,
  input logic tbl_req
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);  // R9
  AST_RSP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));  // R9
  AST_TBL_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    tbl_req |=> !tbl_req);  // R9
  AST_STALL_DURING_FETCH: assert property (@(posedge clk) disable iff (rst)
    tbl_req |-> !req_ready);  // R3
  AST_FAULT_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault_flag |=> fault_flag);  // R5
  AST_FAULT_RSP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> fault_flag);  // R5
endmodule

bind lin_xlat lin_xlat_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .fault_flag(fault_flag),
  .tbl_req(tbl_req)
);

// File: tb/lin_xlat_tb.sv
`timescale 1ns/1ps
module lin_xlat_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_valid, rsp_fault, fault_flag, tbl_req;
  logic [31:0] rsp_pa, tbl_addr;
  logic        tbl_rvalid = 1'b0;
  logic [31:0] tbl_rdata = '0;

  always #4 clk = ~clk;  // 125 MHz

  lin_xlat u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .fault_flag(fault_flag), .tbl_req(tbl_req), .tbl_addr(tbl_addr),
    .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata)
  );

  int n_cmp = 0, n_bad = 0, n_fetch = 0;
  logic [31:0] last_faddr = '0;
  logic [31:0] mem [256];
  int pend = 0;
  logic [31:0] pend_addr = '0;

  // table memory model: data returns two cycles after the read pulse
  always @(negedge clk) begin
    tbl_rvalid = 1'b0;
    if (pend != 0) begin
      pend = pend - 1;
      if (pend == 0) begin
        tbl_rvalid = 1'b1;
        tbl_rdata  = mem[pend_addr[9:2]];
      end
    end
    if (tbl_req) begin
      n_fetch    = n_fetch + 1;
      last_faddr = tbl_addr;
      pend_addr  = tbl_addr;
      pend       = 2;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic xact(input logic wr, input logic [31:0] va, output logic [31:0] pa,
                      output logic flt, output logic vld, output int cyc, output int nf);
    int f0;
    @(negedge clk);
    f0 = n_fetch;
    req_valid = 1'b1; req_write = wr; req_va = va; cyc = 0;
    forever begin
      #1;
      cyc++;
      if (req_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    pa = rsp_pa; flt = rsp_fault; vld = rsp_valid;
    nf = n_fetch - f0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] va;
    logic [31:0] pa;
    logic        flt;
    logic        fetch;
    logic [31:0] faddr;
  } vec_t;

  // window: first page 0x10, range 7, table at 0, fallbacks 0xAAAAA / 0xBBBBB
  localparam vec_t VEC [8] = '{
    '{1'b0, 32'h0001_0123, 32'h0030_0123, 1'b0, 1'b1, 32'h0000_0000},  // R3 miss
    '{1'b0, 32'h0001_0FFF, 32'h0030_0FFF, 1'b0, 1'b0, 32'h0},          // R4 hit
    '{1'b1, 32'h0001_7004, 32'h0030_7004, 1'b0, 1'b1, 32'h0000_001C},  // R3 last page
    '{1'b0, 32'h0001_8000, 32'hAAAA_A000, 1'b1, 1'b0, 32'h0},          // R5 R6 beyond
    '{1'b1, 32'h0000_FABC, 32'hBBBB_BABC, 1'b1, 1'b0, 32'h0},          // R5 R6 below
    '{1'b0, 32'h0001_3456, 32'h0030_3456, 1'b0, 1'b1, 32'h0000_000C},  // R3
    '{1'b1, 32'hFFFF_F001, 32'hBBBB_B001, 1'b1, 1'b0, 32'h0},          // R6 write fault
    '{1'b0, 32'h0001_7FFC, 32'h0030_7FFC, 1'b0, 1'b0, 32'h0}           // R4 hit
  };

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, pa;
    logic flt, vld;
    int cyc, nf;
    for (int i = 0; i < 256; i++) mem[i] = 32'h300 + i;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 fault_flag", 32'(fault_flag), 0);
    cfg_rd(3'd1, rd); chk("R1 ctrl", rd, 32'h0);
    cfg_rd(3'd4, rd); chk("R1 range", rd, 32'h0000_FFFF);
    cfg_rd(3'd0, rd); chk("R1 version", rd & 32'h0000_FF00, 32'h0000_0100);

    // R2 disabled: pass-through
    xact(1'b0, 32'h1234_5678, pa, flt, vld, cyc, nf);
    chk("R2 disabled pa", pa, 32'h1234_5678);
    chk("R2 disabled fetch", 32'(nf), 0);
    chk("R9 rsp_valid", 32'(vld), 1);

    cfg_wr(3'd3, 32'h10);
    cfg_wr(3'd4, 32'h7);
    cfg_wr(3'd5, 32'h0);
    cfg_wr(3'd6, 32'hAAAAA);
    cfg_wr(3'd7, 32'hBBBBB);

    // R10 writable control bits, R2 bypass
    cfg_wr(3'd1, 32'hFFFF_FFFF);
    cfg_rd(3'd1, rd); chk("R10 ctrl readback", rd, 32'h13);
    xact(1'b0, 32'h0001_0123, pa, flt, vld, cyc, nf);
    chk("R2 bypass pa", pa, 32'h0001_0123);
    chk("R2 bypass fetch", 32'(nf), 0);
    chk("R5 flag still clear", 32'(fault_flag), 0);

    cfg_wr(3'd1, 32'h3);
    foreach (VEC[i]) begin
      xact(VEC[i].wr, VEC[i].va, pa, flt, vld, cyc, nf);
      chk($sformatf("R3/R4/R5/R6 vec%0d pa", i), pa, VEC[i].pa);
      chk($sformatf("R5 vec%0d fault", i), 32'(flt), 32'(VEC[i].flt));
      chk($sformatf("R3/R4 vec%0d fetches", i), 32'(nf), 32'(VEC[i].fetch));
      chk($sformatf("R3/R4 vec%0d stalled", i), 32'(cyc > 1), 32'(VEC[i].fetch));
      if (VEC[i].fetch) chk($sformatf("R3 vec%0d table addr", i), last_faddr, VEC[i].faddr);
    end
    chk("R5 sticky flag", 32'(fault_flag), 1);

    // R7 stale entry survives until flush
    mem[0] = 32'h555;
    xact(1'b0, 32'h0001_0010, pa, flt, vld, cyc, nf);
    chk("R7 stale before flush", pa, 32'h0030_0010);
    cfg_wr(3'd2, 32'h0);
    xact(1'b0, 32'h0001_0010, pa, flt, vld, cyc, nf);
    chk("R7 refetch after flush", pa, 32'h0055_5010);
    chk("R7 fetch count", 32'(nf), 1);

    // R8 round-robin replacement
    cfg_wr(3'd2, 32'hDEAD);
    for (int p = 1; p <= 5; p++) begin
      xact(1'b0, 32'h0001_0000 | (p << 12), pa, flt, vld, cyc, nf);
      chk("R8 fill fetch", 32'(nf), 1);
    end
    xact(1'b0, 32'h0001_2000, pa, flt, vld, cyc, nf);
    chk("R8 survivor hits", 32'(nf), 0);
    chk("R8 survivor pa", pa, 32'h0030_2000);
    xact(1'b0, 32'h0001_1000, pa, flt, vld, cyc, nf);
    chk("R8 oldest evicted", 32'(nf), 1);
    chk("R8 evicted pa", pa, 32'h0030_1000);

    // R3 nonzero table base
    cfg_wr(3'd5, 32'h2);
    cfg_wr(3'd2, 32'h0);
    xact(1'b0, 32'h0001_5ABC, pa, flt, vld, cyc, nf);
    chk("R3 base addr", last_faddr, 32'h0000_2014);
    chk("R3 base pa", pa, 32'h0030_5ABC);
    chk("R5 flag held", 32'(fault_flag), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule